// File: doc/BRIEF.md
# Replicated-Bank Multi-Port Register Memory

This block offers a small memory with several independent write ports and several independent read ports. It is built only from storage arrays that each take one write and give one read per cycle. Every write port owns a group of copies, one copy for each read port. A write updates every copy in its own group, so each read port always has a private copy of each group to read from.

A table of flip-flops holds one entry per address. Each entry names the write port that last wrote that address. Each read port looks up this table at the same edge that it reads its copies. One cycle later it uses the registered entry to pick the copy that holds the live value. The block suits register files and small multi-issue queues, where true multi-port storage would be too costly.

Top module: `lvt_mpram`

## Requirements
- R1: A read is synchronous: the address on a read port at a rising edge yields that address's data on the same port's data output from that edge until the next one.
- R2: A value written through any write port is returned by every read port on a later read of that address.
- R3: When several enabled write ports target the same address at one edge, the value of the highest-numbered of them is the one later read back.
- R4: A read of an address that is written at the same edge returns the value that was stored before that edge.
- R5: Reset clears the last-writer table so that every entry names write port 0. After reset, each address reads the data most recently written to it through port 0, even if another port wrote it later before reset.
- R6: A write port whose enable bit is low changes no stored value, whatever its address and data inputs carry.
- R7: Enabled write ports that target different addresses at one edge each store their own value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the last-writer table |
| wr_en | input | NW | Per-port write enable, bit w for write port w |
| wr_addr | input | NW*AW | Write addresses, port w in bits [w*AW +: AW] |
| wr_data | input | NW*DW | Write data, port w in bits [w*DW +: DW] |
| rd_addr | input | NR*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | NR*DW | Read data, port r in bits [r*DW +: DW], one cycle after its address |

## Verification
The bench targets several corner cases. The first is a collision where all write ports hit one address at once. A design with the wrong priority, or with a table that records a different winner than the copy contents, returns a losing port's value. Reading an address in the cycle it is written checks that the table lookup and the copy read are aligned. A misaligned design returns a mix of new data, or the old copy from the new port's group. The bench also writes an address through port 1 over an earlier port 0 value, then applies reset. A table that is not cleared keeps returning the port 1 value. Finally, writes with the enable bit low must leave the stored value unchanged. These directed cases run alongside a long seeded random run that uses few addresses, so collisions happen often.

// File: rtl/lvt_mpram.sv
module lvt_mpram #(
  parameter int NW = 2,
  parameter int NR = 2,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NW*DW-1:0] wr_data,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  localparam int LW = (NW > 1) ? $clog2(NW) : 1;

  logic [LW-1:0] owner [DEPTH];
  logic [LW-1:0] pick_q [NR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) owner[i] <= '0;
    end else begin
      for (int w = 0; w < NW; w++)
        if (wr_en[w]) owner[wr_addr[w*AW +: AW]] <= LW'(w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) pick_q[r] <= '0;
    end else begin
      for (int r = 0; r < NR; r++) pick_q[r] <= owner[rd_addr[r*AW +: AW]];
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    logic [NW*DW-1:0] cand;
    for (genvar w = 0; w < NW; w++) begin : g_wr
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
        if (wr_en[w]) mem[wr_addr[w*AW +: AW]] <= wr_data[w*DW +: DW];
        q <= mem[rd_addr[r*AW +: AW]];
      end
      assign cand[w*DW +: DW] = q;
    end
    assign rd_data[r*DW +: DW] = cand[int'(pick_q[r])*DW +: DW];
  end
endmodule

// File: rtl/lvt_mpram_chk.sv
module lvt_mpram_chk #(
  parameter int NW = 2,
  parameter int NR = 2,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NW-1:0]    wr_en,
  input logic [NW*AW-1:0] wr_addr,
  input logic [NW*DW-1:0] wr_data,
  input logic [NR*AW-1:0] rd_addr,
  input logic [NR*DW-1:0] rd_data
);
  // R3
  top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[NW-1] ##1 (rd_addr[AW-1:0] == $past(wr_addr[(NW-1)*AW +: AW])))
    |=> rd_data[DW-1:0] == $past(wr_data[(NW-1)*DW +: DW], 2));

  // R1
  own_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en == NW'(1)) ##1 (rd_addr[AW-1:0] == $past(wr_addr[AW-1:0])))
    |=> rd_data[DW-1:0] == $past(wr_data[DW-1:0], 2));

  // R2
  own_write_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en == NW'(1)) ##1 (rd_addr[(NR-1)*AW +: AW] == $past(wr_addr[AW-1:0])))
    |=> rd_data[(NR-1)*DW +: DW] == $past(wr_data[DW-1:0], 2));

  // R4 R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(wr_en) == '0) && (rd_addr == $past(rd_addr)))
    |=> $stable(rd_data));
endmodule

bind lvt_mpram lvt_mpram_chk #(.NW(NW), .NR(NR), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/lvt_mpram_tb_top.sv
module lvt_mpram_tb_top;
  localparam int NW = 3, NR = 2, AW = 4, DW = 16;
  localparam int D = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic [NW-1:0] wr_en = '0;
  logic [NW*AW-1:0] wr_addr = '0;
  logic [NW*DW-1:0] wr_data = '0;
  logic [NR*AW-1:0] rd_addr = '0;
  logic [NR*DW-1:0] rd_data;

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_m [D];
  logic [DW-1:0] ref0 [D];

  always #2 clk = ~clk;

  lvt_mpram #(.NW(NW), .NR(NR), .AW(AW), .DW(DW)) dut_i (.*);

  function automatic logic [DW-1:0] pat(int a);
    return DW'(16'h1000 + a * 16'h0101);
  endfunction

  task automatic set_w(int w, bit en, int a, logic [DW-1:0] d);
    wr_en[w] = en;
    wr_addr[w*AW +: AW] = AW'(a);
    wr_data[w*DW +: DW] = d;
  endtask

  task automatic set_r(int r, int a);
    rd_addr[r*AW +: AW] = AW'(a);
  endtask

  task automatic step(string tag, bit chk);
    logic [DW-1:0] ex [NR];
    for (int r = 0; r < NR; r++) ex[r] = ref_m[rd_addr[r*AW +: AW]];
    for (int w = 0; w < NW; w++)
      if (wr_en[w]) begin
        ref_m[wr_addr[w*AW +: AW]] = wr_data[w*DW +: DW];
        if (w == 0) ref0[wr_addr[AW-1:0]] = wr_data[DW-1:0];
      end
    @(negedge clk);
    if (chk)
      for (int r = 0; r < NR; r++) begin
        checks++;
        if (rd_data[r*DW +: DW] !== ex[r]) begin
          fails++;
          $display("FAIL %s port %0d: got %h expected %h", tag, r, rd_data[r*DW +: DW], ex[r]);
        end
      end
  endtask

  task automatic idle();
    for (int w = 0; w < NW; w++) set_w(w, 0, 0, '0);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < D; a++) begin
      idle(); set_w(0, 1, a, pat(a)); step("init", 0);
    end
    idle(); step("init", 0);
    for (int a = 0; a < D; a++) begin
      set_r(0, a); set_r(1, D - 1 - a); step("R1 R2 initial contents", 1);
    end
    // R2: port 1 write, seen by both read ports
    set_w(1, 1, 3, 16'hbeef); step("R2 write", 1);
    idle(); set_r(0, 3); set_r(1, 3); step("R2 read after port 1 write", 1);
    // R4: read the address being written
    set_w(2, 1, 7, 16'hc0de); set_r(0, 7); set_r(1, 7); step("R4 same-edge read old", 1);
    idle(); step("R4 new value next read", 1);
    // R3: all ports collide
    set_w(0, 1, 9, 16'h0a0a); set_w(1, 1, 9, 16'h1b1b); set_w(2, 1, 9, 16'h2c2c);
    step("R3 collide", 1);
    idle(); set_r(0, 9); set_r(1, 9); step("R3 port 2 wins", 1);
    set_w(0, 1, 10, 16'h3d3d); set_w(1, 1, 10, 16'h4e4e); step("R3 collide 0/1", 1);
    idle(); set_r(0, 10); set_r(1, 10); step("R3 port 1 wins", 1);
    // R6: disabled ports carry junk
    set_w(0, 0, 4, 16'hdead); set_w(1, 0, 4, 16'hdead); set_w(2, 0, 4, 16'hdead);
    set_r(0, 4); set_r(1, 4); step("R6 disabled", 1);
    idle(); step("R6 unchanged", 1);
    // R7: distinct addresses at one edge
    set_w(0, 1, 1, 16'h1111); set_w(1, 1, 2, 16'h2222); set_w(2, 1, 12, 16'h3333);
    step("R7 write", 1);
    idle(); set_r(0, 1); set_r(1, 2); step("R7 read 1/2", 1);
    set_r(0, 12); set_r(1, 2); step("R7 read 12", 1);
    // random run, few addresses for many collisions
    for (int n = 0; n < 4000; n++) begin
      for (int w = 0; w < NW; w++)
        set_w(w, $urandom_range(0, 1), $urandom_range(0, 5), DW'($urandom));
      set_r(0, $urandom_range(0, 5)); set_r(1, $urandom_range(0, 5));
      step("R2 R3 R4 random", 1);
    end
    // R5: port 1 overwrites port 0 before reset
    idle(); set_w(0, 1, 5, 16'h5151); step("R5 setup", 1);
    idle(); set_w(1, 1, 5, 16'h5252); step("R5 setup", 1);
    idle(); set_r(0, 5); set_r(1, 5); step("R5 pre-reset", 1);
    rst_n = 0;
    for (int a = 0; a < D; a++) ref_m[a] = ref0[a];
    step("reset", 0); step("reset", 0);
    rst_n = 1;
    for (int a = 0; a < D; a++) begin
      set_r(0, a); set_r(1, a); step("R5 reads port 0 data after reset", 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule